// File: doc/BRIEF.md
# Two-Stage Cascaded Watchdog Timer

This block supervises software with a 14-bit down-counter split into an 8-bit low stage and a 6-bit high stage. Counting advances only on a prescaled one-clock tick strobe. After reset the counter is parked at its full preset and does nothing until software writes the control register once, with any value. Each later write reloads the full preset, so software has to keep writing to the register before the count runs out. If the high stage underflows, the block issues a one-cycle reset request.

A control bit selects how the high stage is clocked. It can be driven by underflows of the low stage, which gives 16384 ticks to timeout. It can instead be driven directly by each tick, bypassing the low stage, which gives 64 ticks. A second control bit can only be set. While it is set, a stop-instruction pulse is treated as an illegal instruction and raises the reset request. Only reset clears this bit. Every reset request also returns the block to its post-reset state.

Top module: `wdt_cascade`

## Requirements
- R1: After reset, rd_data_o reads 0x3F (high stage all ones, bits 7 and 6 zero) and rst_req_o is low.
- R2: Before the first register write, ticks change neither rd_data_o nor rst_req_o.
- R3: A register write loads the low stage with 0xFF and the high stage with 0x3F, starts counting, and stores data bit 7 as the count-source select.
- R4: With bit 7 = 0, the high stage decrements once every 256 ticks. rst_req_o pulses in the cycle after the 16384th tick following a write.
- R5: With bit 7 = 1, the high stage decrements on every tick. rst_req_o pulses in the cycle after the 64th tick following a write.
- R6: Bit 6 (stop disable) is set by writing data bit 6 = 1. A write with data bit 6 = 0 leaves it set.
- R7: A stop_i pulse while bit 6 is 1 raises rst_req_o in the next cycle. While bit 6 is 0, the pulse has no effect.
- R8: rd_data_o returns the high-stage count in bits 5..0, the stop-disable bit in bit 6 and the count-source select in bit 7.
- R9: rst_req_o is high for exactly one cycle. In that cycle the block is already back in its post-reset state: stopped, preset loaded, bits 7 and 6 cleared.
- R10: A write that arrives together with a tick reloads the preset, and that tick is not counted.
- R11: While running, cycles without a tick leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled count-enable strobe, one clock wide |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register read value |
| stop_i | input | 1 | Stop instruction executed pulse |
| rst_req_o | output | 1 | Internal reset request pulse |

## Verification
Every input is registered exactly once before it is seen, so each result appears in the cycle after the edge that samples the stimulus. rd_data_o reflects a write or a counted tick one edge later. rst_req_o rises one edge after the final underflowing tick or the trapped stop pulse, and it falls on the next edge. The bench drives each stimulus at a falling edge, lets a single rising edge pass, and compares both outputs against its model at the next falling edge. Every cycle is compared in this way, including the full 16384-tick timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int LO_W_DEF  = 8;
  localparam int HI_W_DEF  = 6;
  localparam int SRC_BIT   = HI_W_DEF + 1;
  localparam int DIS_BIT   = HI_W_DEF;
endpackage

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '1;
    else if (load_i) cnt_q <= '1;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = dec_i && (cnt_q == '0);

  // R3
  load_preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_o == {W{1'b1}}));

  // R11
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !dec_i) |=> $stable(cnt_o));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wr_src_i,
  input  logic wr_dis_i,
  input  logic evt_i,
  output logic run_o,
  output logic src_o,
  output logic dis_o,
  output logic req_o
);
  logic run_q, src_q, dis_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      src_q <= 1'b0;
      dis_q <= 1'b0;
      req_q <= 1'b0;
    end else if (evt_i) begin
      // self reset: same state as after rst_ni
      run_q <= 1'b0;
      src_q <= 1'b0;
      dis_q <= 1'b0;
      req_q <= 1'b1;
    end else begin
      req_q <= 1'b0;
      if (wr_i) begin
        run_q <= 1'b1;
        src_q <= wr_src_i;
        dis_q <= dis_q | wr_dis_i;
      end
    end
  end

  assign run_o = run_q;
  assign src_o = src_q;
  assign dis_o = dis_q;
  assign req_o = req_q;

  // R6
  dis_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_o && !evt_i) |=> dis_o);

  // R9
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);

  // R9
  req_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (!run_o && !src_o && !dis_o));

  // R2
  idle_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && !wr_i) |=> !run_o);
endmodule

// File: rtl/wdt_cascade.sv
module wdt_cascade
  import wdt_pkg::*;
#(
  parameter int  LO_W  = LO_W_DEF,
  parameter int  HI_W  = HI_W_DEF,
  localparam int REG_W = HI_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             stop_i,
  output logic             rst_req_o
);
  localparam int SRC_POS = HI_W + 1;
  localparam int DIS_POS = HI_W;

  logic            run, src, dis;
  logic            cnt_en, lo_dec, lo_wrap, hi_dec, hi_wrap;
  logic            stop_trap, evt, load;
  logic [LO_W-1:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt;

  // write outranks counting on the same cycle
  assign cnt_en    = tick_i && run && !wr_en_i;
  assign lo_dec    = cnt_en && !src;
  assign hi_dec    = cnt_en && (src || lo_wrap);
  assign stop_trap = stop_i && dis;
  assign evt       = hi_wrap || stop_trap;
  assign load      = wr_en_i || evt;

  wdt_down_cnt #(.W(LO_W)) i_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .dec_i  (lo_dec),
    .cnt_o  (lo_cnt),
    .wrap_o (lo_wrap)
  );

  wdt_down_cnt #(.W(HI_W)) i_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .dec_i  (hi_dec),
    .cnt_o  (hi_cnt),
    .wrap_o (hi_wrap)
  );

  wdt_ctrl i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i),
    .wr_src_i (wr_data_i[SRC_POS]),
    .wr_dis_i (wr_data_i[DIS_POS]),
    .evt_i    (evt),
    .run_o    (run),
    .src_o    (src),
    .dis_o    (dis),
    .req_o    (rst_req_o)
  );

  assign rd_data_o = {src, dis, hi_cnt};

  // R5
  direct_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && src && tick_i && !wr_en_i && !stop_trap && hi_cnt != '0)
      |=> (hi_cnt == $past(hi_cnt) - 1'b1));

  // R4
  chain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !src && !wr_en_i && !stop_trap && lo_cnt != '0) |=> $stable(hi_cnt));

  // R7
  stop_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_trap |=> rst_req_o);

  // R10
  wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !stop_trap) |=> (hi_cnt == {HI_W{1'b1}} && lo_cnt == {LO_W{1'b1}} && !rst_req_o));
endmodule

// File: tb/test_wdt_cascade.sv
module test_wdt_cascade;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       stop_i = 1'b0;
  logic       rst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state
  logic       m_run, m_src, m_dis, m_req;
  logic [7:0] m_lo;
  logic [5:0] m_hi;

  always #2.5 clk_i = ~clk_i;

  wdt_cascade i_wdt_cascade (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .stop_i    (stop_i),
    .rst_req_o (rst_req_o)
  );

  function automatic logic [7:0] m_read();
    return {m_src, m_dis, m_hi};
  endfunction

  task automatic m_clear();
    m_run = 0; m_src = 0; m_dis = 0; m_lo = 8'hFF; m_hi = 6'h3F;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, one rising edge, compare at next negedge
  task automatic step(string tag, bit tk, bit wr, logic [7:0] d, bit stp);
    bit evt = 0;
    tick_i = tk; wr_en_i = wr; wr_data_i = d; stop_i = stp;
    if (stp && m_dis) evt = 1;
    else if (tk && m_run && !wr) begin
      if (m_src) begin
        if (m_hi == 0) evt = 1; else m_hi--;
      end else if (m_lo == 0) begin
        m_lo = 8'hFF;
        if (m_hi == 0) evt = 1; else m_hi--;
      end else m_lo--;
    end
    if (evt) begin
      m_clear(); m_req = 1;
    end else begin
      m_req = 0;
      if (wr) begin
        m_run = 1; m_src = d[7]; m_dis = m_dis | d[6]; m_lo = 8'hFF; m_hi = 6'h3F;
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
    tick_i = 0; wr_en_i = 0; stop_i = 0;
    chk(tag, rd_data_o, m_read());
    chk(tag, rst_req_o, m_req);
  endtask

  initial begin
    #(5ns * 190000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    m_clear(); m_req = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk("R1", rd_data_o, 8'h3F);
    chk("R1", rst_req_o, 1'b0);

    // R2: idle before first write
    for (int i = 0; i < 300; i++) step("R2", 1, 0, 8'h00, 0);
    chk("R2", rd_data_o, 8'h3F);

    // R3/R4: chained mode full timeout
    step("R3", 0, 1, 8'h00, 0);
    chk("R3", rd_data_o, 8'h3F);
    for (int i = 0; i < 255; i++) step("R4", 1, 0, 8'h00, 0);
    chk("R4", rd_data_o, 8'h3F);
    step("R4", 1, 0, 8'h00, 0);
    chk("R4", rd_data_o, 8'h3E);
    for (int i = 0; i < 16384 - 257; i++) step("R4", 1, 0, 8'h00, 0);
    chk("R4", rst_req_o, 1'b0);
    step("R4", 1, 0, 8'h00, 0);
    chk("R4", rst_req_o, 1'b1);
    chk("R9", rd_data_o, 8'h3F);
    step("R9", 1, 0, 8'h00, 0);
    chk("R9", rst_req_o, 1'b0);
    chk("R9", rd_data_o, 8'h3F);

    // R5: direct mode, 64 ticks
    step("R3", 0, 1, 8'h80, 0);
    chk("R8", rd_data_o, 8'hBF);
    step("R5", 1, 0, 8'h00, 0);
    chk("R5", rd_data_o, 8'hBE);
    // R11: no tick, no change
    for (int i = 0; i < 10; i++) step("R11", 0, 0, 8'h00, 0);
    chk("R11", rd_data_o, 8'hBE);
    // R10: write with tick reloads, tick dropped
    step("R10", 1, 1, 8'h80, 0);
    chk("R10", rd_data_o, 8'hBF);
    for (int i = 0; i < 63; i++) step("R5", 1, 0, 8'h00, 0);
    chk("R5", rd_data_o, 8'h80);
    chk("R5", rst_req_o, 1'b0);
    step("R5", 1, 0, 8'h00, 0);
    chk("R5", rst_req_o, 1'b1);

    // R6/R7: sticky stop disable
    step("R7", 0, 0, 8'h00, 1);
    chk("R7", rst_req_o, 1'b0);
    step("R6", 0, 1, 8'h40, 0);
    chk("R6", rd_data_o, 8'h7F);
    step("R6", 0, 1, 8'h00, 0);
    chk("R6", rd_data_o, 8'h7F);
    step("R7", 0, 0, 8'h00, 1);
    chk("R7", rst_req_o, 1'b1);
    chk("R9", rd_data_o, 8'h3F);
    step("R7", 0, 0, 8'h00, 1);
    chk("R7", rst_req_o, 1'b0);

    // R8: constrained random mix against model
    for (int i = 0; i < 6000; i++) begin
      bit tk  = ($urandom % 4) != 0;
      bit wr  = ($urandom % 90) == 0;
      bit stp = ($urandom % 400) == 0;
      logic [7:0] d = 8'($urandom);
      if (($urandom % 3) != 0) d[6] = 1'b0;
      step("R8", tk, wr, d, stp);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule